// File: doc/BRIEF.md
# Edge-Resynchronized Bit Clock Divider

This block derives a receive bit clock from a train of single-cycle carrier pulses. A data bit is sixteen carrier periods long, so a modulo-16 phase counter that steps once per pulse gives one clock period per bit. Interference can insert or remove carrier periods, and the counter then slips against the bit boundaries. To undo the slip, the counter restarts at zero on every low-to-high transition of the received data. A high-to-low transition leaves it untouched.

The data input is asynchronous and passes through a two-stage synchronizer first. The block then drives a recovered clock and a copy of the data that is delayed to match it. A downstream register can capture that data on the rising edge of the clock, which falls near the centre of each bit. Resynchronization never stops, whether or not a real signal is being received.

Top module: `bclk_recovery`

## Requirements
- R1: With no rising data edge, the phase count steps by one, modulo 16, on each cycle where `carrier_ce` is 1. `bit_clk` is 0 for counts 0 to 7 and 1 for counts 8 to 15, so one clock period spans 16 carrier pulses.
- R2: On a cycle where `carrier_ce` is 0 and no rising edge is detected, the count and `bit_clk` keep their values.
- R3: `rx_data` passes through two synchronizer flops and one history flop. `bit_dat` equals the `rx_data` value sampled three clock edges earlier.
- R4: A 0-to-1 change of the synchronized data resets the count to 0. `bit_clk` is therefore 0 from the third clock edge after `rx_data` rises, the same edge at which `bit_dat` becomes 1.
- R5: A 1-to-0 change of the synchronized data has no effect on the count or on `bit_clk`.
- R6: When a rising edge and a `carrier_ce` pulse fall in the same cycle, the count loads 0 and does not step.
- R7: The divider runs and resynchronizes continuously, with no enable or signal-valid qualifier. It free-runs on carrier pulses while the data is constant.
- R8: A synchronous active-high `rst` clears the count, the synchronizer, the edge history, `bit_clk` and `bit_dat` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_ce | input | 1 | Single-cycle pulse, one per carrier period |
| rx_data | input | 1 | Demodulated data bit, asynchronous |
| bit_clk | output | 1 | Recovered bit clock |
| bit_dat | output | 1 | Synchronized data aligned to `bit_clk` |

## Verification
The phase count is hidden, so a wrong value shows up only at `bit_clk`, and only when it crosses the 7/8 or 15/0 boundary. That can take up to eight carrier pulses to appear. A missed or spurious restart moves the clock edges by a whole number of pulses for every following bit, until the next rising data edge. An off-by-one in the synchronizer depth moves both `bit_dat` and the restart point by a cycle. The bench compares both outputs against a behavioural model on every clock, so these faults are caught in the first cycle they become visible.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned CNT_W_DEF = 4;

  // Clock level for a phase count: high in the upper half of the bit.
  function automatic logic phase_level(input logic [CNT_W_DEF-1:0] cnt);
    return cnt[CNT_W_DEF-1];
  endfunction

  // Next phase count: restart beats step, step beats hold.
  function automatic logic [CNT_W_DEF-1:0] phase_next(
      input logic [CNT_W_DEF-1:0] cnt,
      input logic                 step,
      input logic                 restart);
    if (restart)   return '0;
    else if (step) return cnt + 1'b1;
    else           return cnt;
  endfunction
endpackage

// File: rtl/bclk_sync.sv
module bclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bclk_edge.sv
module bclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic last,
  output logic rise
);
  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= level;
  end

  assign rise = level & ~last;
endmodule

// File: rtl/bclk_div.sv
module bclk_div
  import bclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 restart,
  output logic [CNT_W_DEF-1:0] cnt,
  output logic                 level
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= phase_next(cnt, step, restart);
  end

  assign level = phase_level(cnt);
endmodule

// File: rtl/bclk_recovery.sv
module bclk_recovery
  import bclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic carrier_ce,
  input  logic rx_data,
  output logic bit_clk,
  output logic bit_dat
);
  logic                 sync_w;
  logic                 prev_w;
  logic                 rise_w;
  logic [CNT_W_DEF-1:0] cnt_w;

  bclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_data),
    .q   (sync_w)
  );

  bclk_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sync_w),
    .last  (prev_w),
    .rise  (rise_w)
  );

  bclk_div u_div (
    .clk     (clk),
    .rst     (rst),
    .step    (carrier_ce),
    .restart (rise_w),
    .cnt     (cnt_w),
    .level   (bit_clk)
  );

  assign bit_dat = prev_w;
endmodule

// File: rtl/bclk_checker.sv
module bclk_checker
  import bclk_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 ce,
  input logic                 sync,
  input logic                 prev,
  input logic                 rise,
  input logic [CNT_W_DEF-1:0] cnt,
  input logic                 clk_o,
  input logic                 dat_o
);
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!rise && ce) |=> (cnt == CNT_W_DEF'($past(cnt) + 1'b1)));

  assert_clk_rises_mid_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_o) |-> (cnt == CNT_W_DEF'(1 << (CNT_W_DEF - 1))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!rise && !ce) |=> ($stable(cnt) && $stable(clk_o)));

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (sync && !prev) |=> (cnt == '0 && !clk_o && dat_o));

  assert_fall_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (prev && !sync && !ce) |=> $stable(cnt));

  assert_restart_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (rise && ce) |=> (cnt == '0));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !clk_o && !dat_o && !sync));
endmodule

bind bclk_recovery bclk_checker u_chk (
  .clk   (clk),
  .rst   (rst),
  .ce    (carrier_ce),
  .sync  (sync_w),
  .prev  (prev_w),
  .rise  (rise_w),
  .cnt   (cnt_w),
  .clk_o (bit_clk),
  .dat_o (bit_dat)
);

// File: tb/sim_bclk_recovery.sv
module sim_bclk_recovery;
  localparam int BIT_LEN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carrier_ce = 1'b0;
  logic rx_data = 1'b0;
  logic bit_clk, bit_dat;

  int tests = 0;
  int fails = 0;
  string tag = "R8";
  bit done = 0;

  // behavioural reference state
  int m_pipe[$] = '{0, 0, 0};  // [0]=first sync, [1]=second sync, [2]=history
  int m_phase = 0;

  always #5 clk = ~clk;

  bclk_recovery u0 (
    .clk(clk), .rst(rst), .carrier_ce(carrier_ce), .rx_data(rx_data),
    .bit_clk(bit_clk), .bit_dat(bit_dat)
  );

  task automatic check(input string req, input string what, input logic act, input int exp);
    tests++;
    if (act !== exp[0]) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // One cycle: compare at the falling edge, then drive and advance the model.
  task automatic step(input logic r, input logic d, input logic c);
    @(negedge clk);
    check(tag, "bit_clk", bit_clk, (m_phase >= BIT_LEN / 2) ? 1 : 0);
    check("R3", "bit_dat", bit_dat, m_pipe[2]);
    rst = r; rx_data = d; carrier_ce = c;
    if (r) begin
      m_pipe = '{0, 0, 0};
      m_phase = 0;
    end else begin
      if (m_pipe[1] == 1 && m_pipe[2] == 0) m_phase = 0;
      else if (c) m_phase = (m_phase + 1) % BIT_LEN;
      void'(m_pipe.pop_back());
      m_pipe.push_front(d ? 1 : 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin : stim
    // R8: reset state
    tag = "R8";
    repeat (4) step(1, 1, 1);
    // R1 / R7: free running with constant data, pulse every cycle
    tag = "R1";
    repeat (40) step(0, 0, 1);
    tag = "R7";
    repeat (40) step(0, 0, 1);
    // R2: sparse pulses, holding between them
    tag = "R2";
    for (int i = 0; i < 90; i++) step(0, 0, (i % 3) == 0);
    // R4: rising edge mid-count while clock is high
    tag = "R4";
    repeat (10) step(0, 0, 1);
    repeat (20) step(0, 1, 1);
    // R5: falling edge, pulses off around it, then on
    tag = "R5";
    repeat (5) step(0, 0, 0);
    repeat (20) step(0, 0, 1);
    // R6: rising edge with pulse on every cycle, at several phases
    tag = "R6";
    for (int k = 0; k < 6; k++) begin
      repeat (3 + k * 2) step(0, 0, 1);
      repeat (7) step(0, 1, 1);
    end
    // R4 with no pulses at the restart
    tag = "R4";
    repeat (12) step(0, 0, 1);
    repeat (12) step(0, 1, 0);
    repeat (20) step(0, 1, 1);
    // R3 / R7: noisy data and pulses
    tag = "R7";
    for (int i = 0; i < 600; i++) step(0, ($urandom % 5) == 0 ? ~rx_data : rx_data, $urandom % 2);
    // R8: reset in mid-run
    tag = "R8";
    repeat (3) step(1, 1, 1);
    repeat (30) step(0, 1, 1);
    step(0, 1, 1);
    done = 1;
    summary();
  end
endmodule